// File: doc/BRIEF.md
# Byte FIFO Pair with Threshold and Trailing-Data Interrupts

This block sits between a processor register port and a serial bus engine. Software writes bytes to a transmit queue and reads bytes from a receive queue. The serial engine drains the transmit queue with a pop strobe and fills the receive queue with a push strobe. Each queue holds 64 bytes. Software can read back the fill levels and the full and empty flags, and it sets one trigger level per queue.

Level comparisons, misuse of either queue and a quiet-receive timer all feed a sticky interrupt status register. Software clears that register by writing ones. A per-bit enable mask ANDs with the status, and the results OR together into one interrupt line. The quiet-receive timer catches data left behind in the receive queue below its trigger level, so software can collect the tail of a message that never reaches the threshold.

Register access uses a 3-bit word index. Writes take effect at the clock edge. Read data is combinational, so it is valid in the same cycle as the read strobe.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: Each queue is first-in first-out with a capacity of 64 bytes. The status word at index 4 reports:
  - transmit level in bits [6:0], transmit full in bit 7, transmit empty in bit 8;
  - receive level in bits [22:16], receive full in bit 23, receive empty in bit 24.

  Register indices are: 0 control, 1 trailing limit (bits [3:0]), 2 interrupt enable, 3 interrupt status, 4 queue status, 5 transmit data (write), 6 receive data (read). Control holds:
  - receive enable in bit 0 and transmit enable in bit 1;
  - the receive trigger in bits [10:4] and the transmit trigger in bits [22:16].
- R2: After synchronous reset:
  - both levels are 0 and both empty flags are set;
  - interrupt status and enable read 0;
  - the interrupt line is low.
- R3: A write to index 5 while the enabled transmit queue is full drops the byte and sets status bit 3.
- R4: A read of index 6 while the receive queue is empty returns 0 and sets status bit 4.
- R5: A serializer pop while the transmit queue is empty sets status bit 2.
- R6: A serializer push while the enabled receive queue is full drops the byte and sets status bit 5.
- R7: Status bit 0 is set on every clock edge on which transmit is enabled and the transmit level is at or below the transmit trigger.
- R8: Status bit 1 is set on every clock edge on which receive is enabled and the receive level is at or above the receive trigger.
- R9: Status bit 6 is set on the clock edge L+1 cycles after the last receive push, where L is the trailing limit. This requires that the receive queue stays non-empty and below its trigger for that whole time. Every push restarts the count.
- R10: Writing ones to index 3 clears those status bits and leaves the zero bits unchanged. A set condition in the same cycle wins over the clear.
- R11: The interrupt output is high exactly when some status bit and its enable bit (same position) are both 1.
- R12: A queue whose enable bit is 0 is flushed to empty. Writes or pushes to it are dropped and raise no flag.
- R13: A pulse on the transfer-event input sets status bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 3 | Register word index |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops receive data at index 6) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational |
| tx_pop | input | 1 | Serializer takes the transmit head byte |
| tx_byte | output | 8 | Transmit head byte |
| tx_avail | output | 1 | Transmit queue not empty |
| rx_push | input | 1 | Serializer delivers a received byte |
| rx_byte | input | 8 | Received byte |
| xfer_evt | input | 1 | Transfer-event pulse from the bus engine |
| irq | output | 1 | Combined interrupt request |

## Verification
The transmit queue is filled one byte at a time from empty to full, and the level and flags are compared after every write. It is then drained, with the byte order checked. This separates off-by-one errors in level counting, full detection and pointer wrap.

The trailing limit is swept over all sixteen values, each with a single byte pushed. Checking the status one cycle before and exactly at the expected edge exposes any counter that is early or late. A second push in mid-count shows whether the restart works.

Misuse patterns are each applied alone, so a wrong status bit position shows up: a write when full, a pop when empty, a push when full and a read when empty. Disabled-queue stimulus, mixed enable masks and partial clear writes separate the flush, the masking and the per-bit clear behaviour.

// File: rtl/fifo_irq_pkg.sv
package fifo_irq_pkg;

    localparam int FIFO_DEPTH = 64;
    localparam int DATA_W     = 8;
    localparam int LVL_W      = $clog2(FIFO_DEPTH) + 1;
    localparam int IRQ_W      = 10;
    localparam int TRAIL_W    = 4;
    localparam int REG_W      = 32;
    localparam int ADDR_W     = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL  = 3'd0,
        REG_TRAIL = 3'd1,
        REG_IEN   = 3'd2,
        REG_ISTAT = 3'd3,
        REG_FSTAT = 3'd4,
        REG_TXD   = 3'd5,
        REG_RXD   = 3'd6
    } reg_sel_e;

    // control field positions
    localparam int CF_RX_EN   = 0;
    localparam int CF_TX_EN   = 1;
    localparam int CF_RX_TRIG = 4;
    localparam int CF_TX_TRIG = 16;

    // interrupt bit positions (shared by status and enable)
    localparam int IB_TX_AE   = 0;
    localparam int IB_RX_AF   = 1;
    localparam int IB_TX_UR   = 2;
    localparam int IB_TX_OR   = 3;
    localparam int IB_RX_UR   = 4;
    localparam int IB_RX_OR   = 5;
    localparam int IB_TRAIL   = 6;
    localparam int IB_XFER    = 9;

    // queue status field positions
    localparam int FS_TX_LVL   = 0;
    localparam int FS_TX_FULL  = 7;
    localparam int FS_TX_EMPTY = 8;
    localparam int FS_RX_LVL   = 16;
    localparam int FS_RX_FULL  = 23;
    localparam int FS_RX_EMPTY = 24;

    typedef struct packed {
        logic             rx_en;
        logic             tx_en;
        logic [LVL_W-1:0] rx_trig;
        logic [LVL_W-1:0] tx_trig;
    } fifo_cfg_t;

    typedef struct packed {
        logic [LVL_W-1:0] level;
        logic             full;
        logic             empty;
    } fifo_view_t;

    function automatic logic [REG_W-1:0] pack_fstat(fifo_view_t tx, fifo_view_t rx);
        logic [REG_W-1:0] w;
        w = '0;
        w[FS_TX_LVL +: LVL_W] = tx.level;
        w[FS_TX_FULL]         = tx.full;
        w[FS_TX_EMPTY]        = tx.empty;
        w[FS_RX_LVL +: LVL_W] = rx.level;
        w[FS_RX_FULL]         = rx.full;
        w[FS_RX_EMPTY]        = rx.empty;
        return w;
    endfunction

endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 8
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic                         push,
    input  logic [WIDTH-1:0]             din,
    input  logic                         pop,
    output logic [WIDTH-1:0]             dout,
    output logic [$clog2(DEPTH):0]       level,
    output logic                         full,
    output logic                         empty
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = PTR_W + 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign dout    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        level <= LVL_W'(DEPTH)); // R1

    AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !full && !flush) |=> (level == $past(level) + 1'b1)); // R1

endmodule

// File: rtl/trail_timer.sv
module trail_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             armed,
    input  logic [CNT_W-1:0] limit,
    output logic             fire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !armed) cnt <= '0;
        else if (cnt != limit)        cnt <= cnt + 1'b1;
    end

    assign fire = armed && !restart && (cnt == limit);

    AST_TRAIL_RESTART: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0)); // R9

endmodule

// File: rtl/irq_status.sv
module irq_status #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    input  logic [W-1:0] ien,
    output logic [W-1:0] ist,
    output logic         irq
);
    always_ff @(posedge clk) begin
        if (rst) ist <= '0;
        else     ist <= (ist & ~clr) | set;
    end

    assign irq = |(ist & ien);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~set)) |=> ((ist & $past(clr & ~set)) == '0)); // R10

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (rst)
        (|set) |=> ((ist & $past(set)) == $past(set))); // R10

endmodule

// File: rtl/fifo_irq_ctrl.sv
module fifo_irq_ctrl
    import fifo_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              tx_pop,
    output logic [DATA_W-1:0] tx_byte,
    output logic              tx_avail,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              xfer_evt,
    output logic              irq
);
    fifo_cfg_t          cfg;
    logic [TRAIL_W-1:0] trail_lim;
    logic [IRQ_W-1:0]   ien, ist, set_v, clr_v;
    fifo_view_t         txv, rxv;
    logic [DATA_W-1:0]  rx_head;
    logic               wr_ctrl, wr_trail, wr_ien, wr_ist, wr_txd, rd_rxd;
    logic               tx_push, rx_push_ok, trail_fire, trail_armed;
    logic               wdata_unused;

    assign wr_ctrl  = reg_wr && (reg_addr == REG_CTRL);
    assign wr_trail = reg_wr && (reg_addr == REG_TRAIL);
    assign wr_ien   = reg_wr && (reg_addr == REG_IEN);
    assign wr_ist   = reg_wr && (reg_addr == REG_ISTAT);
    assign wr_txd   = reg_wr && (reg_addr == REG_TXD);
    assign rd_rxd   = reg_rd && (reg_addr == REG_RXD);

    assign wdata_unused = ^{reg_wdata[REG_W-1:CF_TX_TRIG+LVL_W],
                            reg_wdata[CF_TX_TRIG-1:CF_RX_TRIG+LVL_W],
                            reg_wdata[CF_RX_TRIG-1:CF_TX_EN+1]};

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg       <= '0;
            trail_lim <= '0;
            ien       <= '0;
        end else begin
            if (wr_ctrl) begin
                cfg.rx_en   <= reg_wdata[CF_RX_EN];
                cfg.tx_en   <= reg_wdata[CF_TX_EN];
                cfg.rx_trig <= reg_wdata[CF_RX_TRIG +: LVL_W];
                cfg.tx_trig <= reg_wdata[CF_TX_TRIG +: LVL_W];
            end
            if (wr_trail) trail_lim <= reg_wdata[TRAIL_W-1:0];
            if (wr_ien)   ien       <= reg_wdata[IRQ_W-1:0];
        end
    end

    assign tx_push    = wr_txd && cfg.tx_en;
    assign rx_push_ok = rx_push && cfg.rx_en;

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_tx_fifo (
        .clk(clk), .rst(rst), .flush(!cfg.tx_en),
        .push(tx_push), .din(reg_wdata[DATA_W-1:0]),
        .pop(tx_pop), .dout(tx_byte),
        .level(txv.level), .full(txv.full), .empty(txv.empty)
    );

    byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_rx_fifo (
        .clk(clk), .rst(rst), .flush(!cfg.rx_en),
        .push(rx_push_ok), .din(rx_byte),
        .pop(rd_rxd), .dout(rx_head),
        .level(rxv.level), .full(rxv.full), .empty(rxv.empty)
    );

    assign tx_avail    = !txv.empty;
    assign trail_armed = cfg.rx_en && !rxv.empty && (rxv.level < cfg.rx_trig);

    trail_timer #(.CNT_W(TRAIL_W)) u_trail (
        .clk(clk), .rst(rst), .restart(rx_push_ok), .armed(trail_armed),
        .limit(trail_lim), .fire(trail_fire)
    );

    always_comb begin
        set_v           = '0;
        set_v[IB_TX_AE] = cfg.tx_en && (txv.level <= cfg.tx_trig);
        set_v[IB_RX_AF] = cfg.rx_en && (rxv.level >= cfg.rx_trig);
        set_v[IB_TX_UR] = tx_pop && txv.empty;
        set_v[IB_TX_OR] = tx_push && txv.full;
        set_v[IB_RX_UR] = rd_rxd && rxv.empty;
        set_v[IB_RX_OR] = rx_push_ok && rxv.full;
        set_v[IB_TRAIL] = trail_fire;
        set_v[IB_XFER]  = xfer_evt;
    end

    assign clr_v = wr_ist ? reg_wdata[IRQ_W-1:0] : '0;

    irq_status #(.W(IRQ_W)) u_irq (
        .clk(clk), .rst(rst), .set(set_v), .clr(clr_v),
        .ien(ien), .ist(ist), .irq(irq)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            REG_CTRL: begin
                reg_rdata[CF_RX_EN]             = cfg.rx_en;
                reg_rdata[CF_TX_EN]             = cfg.tx_en;
                reg_rdata[CF_RX_TRIG +: LVL_W]  = cfg.rx_trig;
                reg_rdata[CF_TX_TRIG +: LVL_W]  = cfg.tx_trig;
            end
            REG_TRAIL: reg_rdata[TRAIL_W-1:0] = trail_lim;
            REG_IEN:   reg_rdata[IRQ_W-1:0]   = ien;
            REG_ISTAT: reg_rdata[IRQ_W-1:0]   = ist;
            REG_FSTAT: reg_rdata              = pack_fstat(txv, rxv);
            REG_RXD:   reg_rdata[DATA_W-1:0]  = rxv.empty ? '0 : rx_head;
            default:   reg_rdata              = '0;
        endcase
    end

    AST_TX_OVR_FLAG: assert property (@(posedge clk) disable iff (rst)
        (wr_txd && cfg.tx_en && txv.full) |=> ist[IB_TX_OR]); // R3

    AST_RX_UR_ZERO: assert property (@(posedge clk) disable iff (rst)
        (rd_rxd && rxv.empty) |-> (reg_rdata == '0)); // R4

    AST_RX_OVR_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (rx_push_ok && rxv.full && !rd_rxd) |=> (rxv.level == LVL_W'(FIFO_DEPTH))); // R6

endmodule

// File: tb/test_fifo_irq_ctrl.sv
module test_fifo_irq_ctrl;
    import fifo_irq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic              reg_wr = 1'b0, reg_rd = 1'b0;
    logic [REG_W-1:0]  reg_wdata = '0;
    logic [REG_W-1:0]  reg_rdata;
    logic              tx_pop = 1'b0;
    logic [DATA_W-1:0] tx_byte;
    logic              tx_avail;
    logic              rx_push = 1'b0;
    logic [DATA_W-1:0] rx_byte = '0;
    logic              xfer_evt = 1'b0;
    logic              irq;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    fifo_irq_ctrl i_fifo_irq_ctrl (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .tx_avail(tx_avail), .rx_push(rx_push), .rx_byte(rx_byte), .xfer_evt(xfer_evt),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] fst(int txl, int rxl);
        logic [31:0] f = '0;
        f[6:0]   = 7'(txl);
        f[7]     = (txl == 64);
        f[8]     = (txl == 0);
        f[22:16] = 7'(rxl);
        f[23]    = (rxl == 64);
        f[24]    = (rxl == 0);
        return f;
    endfunction

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [31:0] d);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        reg_rd = 1'b0;
    endtask

    task automatic rd_rx(output logic [31:0] d);
        @(negedge clk);
        reg_addr = 3'd6; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_byte = b; rx_push = 1'b1;
        @(negedge clk);
        rx_push = 1'b0;
    endtask

    task automatic pop_tx(input bit check, input logic [7:0] exp);
        @(negedge clk);
        tx_pop = 1'b1;
        #1 if (check) chk("R1 tx order", {24'h0, tx_byte}, {24'h0, exp});
        @(negedge clk);
        tx_pop = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        peek(3'd4, d); chk("R2 fstat", d, fst(0, 0));
        peek(3'd3, d); chk("R2 istat", d, 32'h0);
        peek(3'd2, d); chk("R2 ien", d, 32'h0);
        chk("R2 irq", {31'h0, irq}, 32'h0);

        // enable both, rx trigger 8, tx trigger 4
        wr(3'd0, 32'h0004_0083);
        @(negedge clk);
        peek(3'd3, d); chk("R7 ae at empty", {31'h0, d[0]}, 32'h1);
        wr(3'd3, 32'h1);
        peek(3'd3, d); chk("R10 set wins", {31'h0, d[0]}, 32'h1);

        // R1 fill transmit queue
        for (int i = 0; i < 64; i++) begin
            wr(3'd5, 32'((i * 3 + 1) & 8'hFF));
            peek(3'd4, d); chk("R1 tx fill", d, fst(i + 1, 0));
        end
        wr(3'd3, 32'h3FF);
        peek(3'd3, d); chk("R10 clear all", d, 32'h0);
        wr(3'd5, 32'hEE);
        peek(3'd3, d); chk("R3 tx overrun", d, 32'h8);
        peek(3'd4, d); chk("R3 level held", d, fst(64, 0));

        // drain
        for (int i = 0; i < 64; i++) begin
            pop_tx(1'b1, 8'((i * 3 + 1) & 8'hFF));
            if (i == 58) begin
                peek(3'd3, d); chk("R7 ae above trigger", {31'h0, d[0]}, 32'h0);
            end
        end
        peek(3'd3, d); chk("R7 ae after drain", {31'h0, d[0]}, 32'h1);
        peek(3'd4, d); chk("R1 tx drained", d, fst(0, 0));
        pop_tx(1'b0, 8'h0);
        peek(3'd3, d); chk("R5 tx underrun", {31'h0, d[2]}, 32'h1);

        // R11 masking
        wr(3'd2, 32'h40);
        chk("R11 masked", {31'h0, irq}, 32'h0);
        wr(3'd2, 32'h4);
        chk("R11 enabled", {31'h0, irq}, 32'h1);
        wr(3'd3, 32'h4);
        chk("R11 cleared", {31'h0, irq}, 32'h0);
        peek(3'd3, d); chk("R10 zero bits kept", {31'h0, d[3]}, 32'h1);
        wr(3'd2, 32'h0);

        // R9 trailing sweep over every limit
        for (int lim = 0; lim < 16; lim++) begin
            wr(3'd1, 32'(lim));
            wr(3'd3, 32'h3FF);
            push_rx(8'(8'h40 + lim));
            repeat (lim) @(negedge clk);
            peek(3'd3, d); chk("R9 trail early", {31'h0, d[6]}, 32'h0);
            @(negedge clk);
            peek(3'd3, d); chk("R9 trail fires", {31'h0, d[6]}, 32'h1);
            rd_rx(d); chk("R1 rx byte", d, 32'(8'h40 + lim));
        end
        // R9 restart on second push
        wr(3'd1, 32'd5);
        wr(3'd3, 32'h3FF);
        push_rx(8'h11);
        repeat (3) @(negedge clk);
        push_rx(8'h22);
        repeat (5) @(negedge clk);
        peek(3'd3, d); chk("R9 restart", {31'h0, d[6]}, 32'h0);
        @(negedge clk);
        peek(3'd3, d); chk("R9 restart fires", {31'h0, d[6]}, 32'h1);
        rd_rx(d); chk("R1 rx first", d, 32'h11);
        rd_rx(d); chk("R1 rx second", d, 32'h22);

        // R8 / R6 receive fill
        wr(3'd1, 32'd15);
        wr(3'd3, 32'h3FF);
        for (int i = 0; i < 64; i++) begin
            push_rx(8'(8'hA0 ^ i));
            if (i == 6) begin
                peek(3'd3, d); chk("R8 af below", {31'h0, d[1]}, 32'h0);
            end
            if (i == 8) begin
                peek(3'd3, d); chk("R8 af at trigger", {31'h0, d[1]}, 32'h1);
            end
        end
        push_rx(8'h5A);
        peek(3'd3, d); chk("R6 rx overrun", {31'h0, d[5]}, 32'h1);
        peek(3'd4, d); chk("R6 level held", d, fst(0, 64));
        for (int i = 0; i < 64; i++) begin
            rd_rx(d); chk("R1 rx order", d, 32'(8'hA0 ^ i));
        end
        rd_rx(d); chk("R4 empty read", d, 32'h0);
        peek(3'd3, d); chk("R4 rx underrun", {31'h0, d[4]}, 32'h1);

        // R13 transfer event
        wr(3'd3, 32'h3FF);
        @(negedge clk); xfer_evt = 1'b1;
        @(negedge clk); xfer_evt = 1'b0;
        peek(3'd3, d); chk("R13 xfer", {31'h0, d[9]}, 32'h1);

        // R12 disable flushes and drops
        wr(3'd5, 32'h01);
        wr(3'd5, 32'h02);
        peek(3'd4, d); chk("R12 before", d, fst(2, 0));
        wr(3'd0, 32'h0004_0081);
        @(negedge clk);
        peek(3'd4, d); chk("R12 flushed", d, fst(0, 0));
        wr(3'd3, 32'h3FF);
        wr(3'd5, 32'h55);
        peek(3'd4, d); chk("R12 dropped", d, fst(0, 0));
        peek(3'd3, d); chk("R12 no flags", {30'h0, d[3], d[0]}, 32'h0);
        chk("R12 tx_avail", {31'h0, tx_avail}, 32'h0);

        finish_run();
    end
endmodule